// File: doc/BRIEF.md
# DMA Channel Launch Register Front End

This block is the software-facing register file of a seven-slot DMA controller. Every channel slot owns three 32-bit registers: a memory address, a block-control word and a channel-control word. A shared primary control register packs one enable bit per channel, one bit in each 4-bit group. A status register collects one sticky error bit per channel.

Software writes a channel-control word whose bit 24 (the go/busy bit) is set. If that channel's enable bit in the primary control register is also set, the block emits a one-cycle launch pulse toward the transfer engine. The pulse carries the channel's stored address, its block-control value and the newly written control word. The engine later returns a one-cycle done pulse, and the go bit in the stored control word drops.

Slot 5 has no channel behind it. It keeps no state and never launches.

Top module: `dma_start_gate`

## Requirements
- R1: After reset every register reads zero and no launch pulse is active.
- R2: Channel n (n other than 5) has three read/write registers. The address register is at 0x80+0x10·n, the block-control register at +4 and the channel-control register at +8. Each reads back the last value written.
- R3: The primary control register at 0xF0 is a 32-bit read/write register. Channel n's enable bit is bit 4·n+3.
- R4: A write to channel n's control register with bit 24 set, while enable bit 4·n+3 is set, raises `start_pulse[n]` for exactly one cycle, in the cycle after the write. During that cycle the `start_addr`, `start_blk` and `start_ctl` lanes n (32 bits each, lane n at bits 32·n and up) carry the stored address, the stored block control and the written control word.
- R5: A control write with bit 24 set does not launch when the channel's own enable bit is clear, even if other channels' enable bits are set. The value is still stored.
- R6: A control write with bit 24 clear never launches.
- R7: A one-cycle `done[n]` clears bit 24 of channel n's stored control word and keeps all its other bits. If a control write to the same channel lands in the same cycle, the written value is stored.
- R8: A control write with bit 24 set, while the stored word already has bit 24 set, sets status bit n at 0xF4. The bit stays set until reset. The launch still follows the rules of R4.
- R9: Slot 5 is ignored. Writes to 0xD0, 0xD4 and 0xD8 have no effect, those addresses read zero, and slot 5 never launches, whatever its enable bit holds.
- R10: Unmapped addresses read zero. The status register is read-only: writes to 0xF4 leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| done | input | 7 | Per-channel transfer-complete pulses |
| start_pulse | output | 7 | Per-channel one-cycle launch pulses |
| start_addr | output | 224 | Launch address, one 32-bit lane per channel |
| start_blk | output | 224 | Launch block control, one lane per channel |
| start_ctl | output | 224 | Launch control word, one lane per channel |

## Verification
The bench enables one channel and then starts a different channel, to catch gating that reads the wrong nibble of the primary register. Such a design would launch from a neighbour's enable bit. A second start written to a channel that is still busy must set only that channel's status bit and must still launch; a design that tests the new value instead of the stored one would flag first starts too. A done pulse that coincides with a control write checks the write-priority rule, and a broken priority shows up as a missing go bit. Slot 5 is written with its enable bit set, so a design that decodes the slot like the others would read back data or launch.

// File: rtl/dma_gate_pkg.sv
package dma_gate_pkg;
   // register selector inside one channel slot
   typedef enum logic [1:0] {
      FLD_ADDR = 2'd0,
      FLD_BLK  = 2'd1,
      FLD_CTL  = 2'd2,
      FLD_NONE = 2'd3
   } fld_e;
endpackage

// File: rtl/dma_chan_slot.sv
module dma_chan_slot #(
   parameter int DW     = 32,
   parameter int GO_BIT = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_addr_i,
   input  logic          wr_blk_i,
   input  logic          wr_ctl_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          en_i,
   input  logic          done_i,
   output logic [DW-1:0] addr_q_o,
   output logic [DW-1:0] blk_q_o,
   output logic [DW-1:0] ctl_q_o,
   output logic          start_o,
   output logic [DW-1:0] start_addr_o,
   output logic [DW-1:0] start_blk_o,
   output logic [DW-1:0] start_ctl_o,
   output logic          err_o
);
   logic go_req, launch, restart;

   assign go_req  = wr_ctl_i && wdata_i[GO_BIT];
   assign launch  = go_req && en_i;
   assign restart = go_req && ctl_q_o[GO_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q_o     <= '0;
         blk_q_o      <= '0;
         ctl_q_o      <= '0;
         start_o      <= 1'b0;
         start_addr_o <= '0;
         start_blk_o  <= '0;
         start_ctl_o  <= '0;
         err_o        <= 1'b0;
      end else begin
         if (wr_addr_i) addr_q_o <= wdata_i;
         if (wr_blk_i)  blk_q_o  <= wdata_i;
         if (wr_ctl_i)  ctl_q_o  <= wdata_i;
         else if (done_i) ctl_q_o[GO_BIT] <= 1'b0;
         start_o <= launch;
         if (launch) begin
            start_addr_o <= addr_q_o;
            start_blk_o  <= blk_q_o;
            start_ctl_o  <= wdata_i;
         end
         if (restart) err_o <= 1'b1;
      end
   end

   // R4
   go_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl_i && wdata_i[GO_BIT] && en_i) |=> (start_o && start_ctl_o[GO_BIT]));
   // R5
   no_enable_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl_i && !en_i) |=> !start_o);
   // R6
   idle_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ctl_i && wdata_i[GO_BIT]) |=> !start_o);
   // R7
   done_clears_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !wr_ctl_i) |=> !ctl_q_o[GO_BIT]);
   // R8
   restart_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl_i && wdata_i[GO_BIT] && ctl_q_o[GO_BIT]) |=> err_o);
   // R8
   sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);
endmodule

// File: rtl/dma_read_mux.sv
module dma_read_mux #(
   parameter int NUM_CH       = 7,
   parameter int DW           = 32,
   parameter int AW           = 8,
   parameter int CH_BASE      = 'h80,
   parameter int CH_STRIDE    = 'h10,
   parameter int PRIMARY_ADDR = 'hF0,
   parameter int STATUS_ADDR  = 'hF4
) (
   input  logic [AW-1:0]        addr_i,
   input  logic [NUM_CH*DW-1:0] addr_regs_i,
   input  logic [NUM_CH*DW-1:0] blk_regs_i,
   input  logic [NUM_CH*DW-1:0] ctl_regs_i,
   input  logic [DW-1:0]        primary_i,
   input  logic [DW-1:0]        status_i,
   output logic [DW-1:0]        rdata_o
);
   always_comb begin
      rdata_o = '0;
      if (addr_i == AW'(PRIMARY_ADDR)) rdata_o = primary_i;
      if (addr_i == AW'(STATUS_ADDR))  rdata_o = status_i;
      for (int n = 0; n < NUM_CH; n++) begin
         if (addr_i == AW'(CH_BASE + CH_STRIDE*n))     rdata_o = addr_regs_i[n*DW +: DW];
         if (addr_i == AW'(CH_BASE + CH_STRIDE*n + 4)) rdata_o = blk_regs_i[n*DW +: DW];
         if (addr_i == AW'(CH_BASE + CH_STRIDE*n + 8)) rdata_o = ctl_regs_i[n*DW +: DW];
      end
   end
endmodule

// File: rtl/dma_start_gate.sv
module dma_start_gate
   import dma_gate_pkg::*;
#(
   parameter int NUM_CH       = 7,
   parameter int DW           = 32,
   parameter int AW           = 8,
   parameter int GO_BIT       = 24,
   parameter int CH_BASE      = 'h80,
   parameter int CH_STRIDE    = 'h10,
   parameter int ABSENT_CH    = 5,
   parameter int PRIMARY_ADDR = 'hF0,
   parameter int STATUS_ADDR  = 'hF4,
   parameter int EN_STRIDE    = 4,
   parameter int EN_OFS       = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [AW-1:0]        reg_addr,
   input  logic [DW-1:0]        reg_wdata,
   output logic [DW-1:0]        reg_rdata,
   input  logic [NUM_CH-1:0]    done,
   output logic [NUM_CH-1:0]    start_pulse,
   output logic [NUM_CH*DW-1:0] start_addr,
   output logic [NUM_CH*DW-1:0] start_blk,
   output logic [NUM_CH*DW-1:0] start_ctl
);
   localparam int MAP_END = CH_BASE + CH_STRIDE*NUM_CH;
   localparam int TOP_EN  = EN_STRIDE*(NUM_CH-1) + EN_OFS;

   if (MAP_END > PRIMARY_ADDR) begin : g_bad_map
      $error("channel window overlaps primary control register");
   end
   if (TOP_EN >= DW || NUM_CH > DW || GO_BIT >= DW || CH_STRIDE < 12) begin : g_bad_width
      $error("field layout does not fit the data width");
   end

   logic [DW-1:0]        primary_q;
   logic [NUM_CH-1:0]    err_vec;
   logic [NUM_CH*DW-1:0] addr_regs, blk_regs, ctl_regs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primary_q <= '0;
      else if (reg_wr && reg_addr == AW'(PRIMARY_ADDR)) primary_q <= reg_wdata;
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      localparam int BASE = CH_BASE + CH_STRIDE*n;
      fld_e fld;
      always_comb begin
         if      (reg_addr == AW'(BASE))     fld = FLD_ADDR;
         else if (reg_addr == AW'(BASE + 4)) fld = FLD_BLK;
         else if (reg_addr == AW'(BASE + 8)) fld = FLD_CTL;
         else                                fld = FLD_NONE;
      end
      if (n == ABSENT_CH) begin : g_absent
         logic unused_sel;
         assign unused_sel = (fld == FLD_NONE) ^ done[n];
         assign addr_regs[n*DW +: DW]  = '0;
         assign blk_regs[n*DW +: DW]   = '0;
         assign ctl_regs[n*DW +: DW]   = '0;
         assign start_pulse[n]         = 1'b0;
         assign start_addr[n*DW +: DW] = '0;
         assign start_blk[n*DW +: DW]  = '0;
         assign start_ctl[n*DW +: DW]  = '0;
         assign err_vec[n]             = 1'b0;
      end else begin : g_live
         dma_chan_slot #(.DW(DW), .GO_BIT(GO_BIT)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_addr_i    (reg_wr && fld == FLD_ADDR),
            .wr_blk_i     (reg_wr && fld == FLD_BLK),
            .wr_ctl_i     (reg_wr && fld == FLD_CTL),
            .wdata_i      (reg_wdata),
            .en_i         (primary_q[EN_STRIDE*n + EN_OFS]),
            .done_i       (done[n]),
            .addr_q_o     (addr_regs[n*DW +: DW]),
            .blk_q_o      (blk_regs[n*DW +: DW]),
            .ctl_q_o      (ctl_regs[n*DW +: DW]),
            .start_o      (start_pulse[n]),
            .start_addr_o (start_addr[n*DW +: DW]),
            .start_blk_o  (start_blk[n*DW +: DW]),
            .start_ctl_o  (start_ctl[n*DW +: DW]),
            .err_o        (err_vec[n])
         );
      end
   end

   dma_read_mux #(
      .NUM_CH(NUM_CH), .DW(DW), .AW(AW), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE),
      .PRIMARY_ADDR(PRIMARY_ADDR), .STATUS_ADDR(STATUS_ADDR)
   ) u_rmux (
      .addr_i      (reg_addr),
      .addr_regs_i (addr_regs),
      .blk_regs_i  (blk_regs),
      .ctl_regs_i  (ctl_regs),
      .primary_i   (primary_q),
      .status_i    ({{(DW-NUM_CH){1'b0}}, err_vec}),
      .rdata_o     (reg_rdata)
   );

   // R9
   absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == AW'(CH_BASE + CH_STRIDE*ABSENT_CH + 8)) |-> (reg_rdata == '0));
   // R3
   primary_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == AW'(PRIMARY_ADDR)) |=> $stable(primary_q));
endmodule

// File: tb/dma_start_gate_tb.sv
module dma_start_gate_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0;
   logic [7:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic [6:0]   done = '0;
   logic [6:0]   start_pulse;
   logic [223:0] start_addr, start_blk, start_ctl;
   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   dma_start_gate u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
      .start_pulse(start_pulse), .start_addr(start_addr),
      .start_blk(start_blk), .start_ctl(start_ctl)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(reg_rdata === exp, req, reg_rdata, exp);
   endtask

   task automatic pulse_chk(input logic [6:0] exp, input string req);
      check(start_pulse === exp, req, 32'(start_pulse), 32'(exp));
   endtask

   task automatic t_reset;
      pulse_chk(7'h0, "R1 pulse");
      rd_chk(8'h80, 0, "R1 addr0");
      rd_chk(8'hE8, 0, "R1 ctl6");
      rd_chk(8'hF0, 0, "R1 primary");
      rd_chk(8'hF4, 0, "R1 status");
   endtask

   task automatic t_regs;
      wr(8'hA0, 32'h0001_2340);
      wr(8'hA4, 32'h0005_0010);
      wr(8'hE0, 32'h00AB_CDE0);
      rd_chk(8'hA0, 32'h0001_2340, "R2 addr2");
      rd_chk(8'hA4, 32'h0005_0010, "R2 blk2");
      rd_chk(8'hE0, 32'h00AB_CDE0, "R2 addr6");
   endtask

   task automatic t_primary;
      wr(8'hF0, 32'h0800_0808);
      rd_chk(8'hF0, 32'h0800_0808, "R3 primary");
   endtask

   task automatic t_start;
      wr(8'hA8, 32'h0100_0201);
      pulse_chk(7'h04, "R4 pulse");
      check(start_addr[64 +: 32] === 32'h0001_2340, "R4 addr", start_addr[64 +: 32], 32'h0001_2340);
      check(start_blk[64 +: 32] === 32'h0005_0010, "R4 blk", start_blk[64 +: 32], 32'h0005_0010);
      check(start_ctl[64 +: 32] === 32'h0100_0201, "R4 ctl", start_ctl[64 +: 32], 32'h0100_0201);
      @(negedge clk);
      pulse_chk(7'h00, "R4 one cycle");
   endtask

   task automatic t_done;
      @(negedge clk); done = 7'h04;
      @(negedge clk); done = 7'h00;
      rd_chk(8'hA8, 32'h0000_0201, "R7 go cleared");
   endtask

   task automatic t_no_enable;
      wr(8'h98, 32'h0100_0000);
      pulse_chk(7'h00, "R5 channel1 gated");
      rd_chk(8'h98, 32'h0100_0000, "R5 stored");
   endtask

   task automatic t_no_go;
      wr(8'h88, 32'h0000_0401);
      pulse_chk(7'h00, "R6 idle write");
      rd_chk(8'h88, 32'h0000_0401, "R6 stored");
   endtask

   task automatic t_restart;
      rd_chk(8'hF4, 0, "R8 clear before");
      wr(8'hA8, 32'h0100_0000);
      pulse_chk(7'h04, "R8 first start");
      rd_chk(8'hF4, 0, "R8 first start no flag");
      wr(8'hA8, 32'h0100_0001);
      pulse_chk(7'h04, "R8 restart still launches");
      wr(8'h98, 32'h0100_0000);
      rd_chk(8'hF4, 32'h0000_0006, "R8 flags");
      @(negedge clk); done = 7'h06;
      @(negedge clk); done = 7'h00;
      rd_chk(8'hF4, 32'h0000_0006, "R8 sticky");
   endtask

   task automatic t_done_vs_write;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 8'h88; reg_wdata = 32'h0100_0003; done = 7'h01;
      @(negedge clk);
      reg_wr = 1'b0; done = 7'h00;
      pulse_chk(7'h01, "R7 write wins launch");
      rd_chk(8'h88, 32'h0100_0003, "R7 write wins");
   endtask

   task automatic t_absent;
      wr(8'hF0, 32'h0080_0008);
      wr(8'hD0, 32'hDEAD_0000);
      wr(8'hD4, 32'h0000_BEEF);
      wr(8'hD8, 32'h0100_0000);
      pulse_chk(7'h00, "R9 no launch");
      rd_chk(8'hD0, 0, "R9 addr");
      rd_chk(8'hD4, 0, "R9 blk");
      rd_chk(8'hD8, 0, "R9 ctl");
   endtask

   task automatic t_misc;
      rd_chk(8'h8C, 0, "R10 gap");
      rd_chk(8'h00, 0, "R10 low");
      wr(8'hF4, 32'hFFFF_FFFF);
      rd_chk(8'hF4, 32'h0000_0006, "R10 status read-only");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_primary();
      t_start();
      t_done();
      t_no_enable();
      t_no_go();
      t_restart();
      t_done_vs_write();
      t_absent();
      t_misc();
      finished = 1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule